// File: doc/BRIEF.md
# Lifting Wavelet Predict Stage

This block is the predict half of an integer lifting wavelet step for a stream of 8-bit grayscale pixels. Pixels arrive one per clock with a valid strobe. Within a line they alternate even, odd, even, and so on. For every odd pixel the block emits a detail coefficient. The coefficient is the odd pixel minus the floor of the mean of the even pixels on either side of it. Alongside it the block passes through the left even pixel as the approximation sample.

Pixels are unsigned and details are signed two's complement, one bit wider than a pixel. A line-end flag comes with the final pixel of each line, which is always an odd position. On that pixel there is no even pixel to its right, so the left even pixel stands in for it (symmetric extension). Idle cycles may appear anywhere in the stream.

Top module: `wlet_predict`

## Requirements
- R1: For an odd pixel o with even neighbours l (left) and r (right), detail_o equals o - floor((l + r) / 2). With l=66, o=48, r=39 the result is -4, which is 9'h1FC on detail_o.
- R2: detail_o is a 9-bit two's-complement value and covers the full range -255 to +255. With l=r=255, o=0 it is -255. With l=r=0, o=255 it is +255.
- R3: The sum l + r is formed without wrap-around. With l=r=255, o=200 the detail is -55.
- R4: approx_o carries the left even pixel l of the triple whose detail is presented in the same cycle.
- R5: Take cycle n as the cycle in which the pixel that completes a triple is presented. valid_o is high for exactly that one triple in cycle n+2. valid_o is low in every other cycle.
- R6: valid_o stays low after reset until a complete triple has been received.
- R7: When last_i is high on an odd pixel, the left even pixel is used as the right neighbour, so detail_o = o - l.
- R8: A cycle with valid_i low has no effect on pairing or on any later result.
- R9: The pixel that follows a line end is taken as the first even pixel of a new line, and its arrival produces no output.
- R10: While rst_ni is low, valid_o, detail_o and approx_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 8 | Unsigned input pixel |
| valid_i | input | 1 | pix_i carries a pixel this cycle |
| last_i | input | 1 | Final pixel of the line; honoured only on odd pixels |
| valid_o | output | 1 | detail_o and approx_o are valid |
| detail_o | output | 9 | Signed detail coefficient |
| approx_o | output | 8 | Left even pixel of the triple |

## Verification
The assertions assume that every line holds an even number of pixels, so last_i is raised only on an odd pixel, and that inputs carry no unknown values while valid_i is high. The random stimulus builds each line with an even length between 2 and 16. It raises last_i only on the final pixel of a line and holds it low at every other position. The idle cycles it inserts between pixels never change the pixel order within a line.

// File: rtl/wlp_pkg.sv
package wlp_pkg;
  typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_e;
endpackage

// File: rtl/wlp_pair_ctrl.sv
module wlp_pair_ctrl
  import wlp_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             valid_i,
  input  logic             last_i,
  output logic             trip_v_o,
  output logic [PIX_W-1:0] left_o,
  output logic [PIX_W-1:0] odd_o,
  output logic [PIX_W-1:0] right_o
);
  phase_e           phase_q;
  logic [PIX_W-1:0] even_q, odd_q;
  logic             pend_q;
  logic             take_even, take_odd;

  assign take_even = valid_i && (phase_q == PH_EVEN);
  assign take_odd  = valid_i && (phase_q == PH_ODD);

  // a triple closes on the next even pixel, or on a line-final odd pixel (mirror)
  assign trip_v_o = (take_even && pend_q) || (take_odd && last_i);
  assign left_o   = even_q;
  assign odd_o    = take_odd ? pix_i  : odd_q;
  assign right_o  = take_odd ? even_q : pix_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_EVEN;
      even_q  <= '0;
      odd_q   <= '0;
      pend_q  <= 1'b0;
    end else if (take_even) begin
      even_q  <= pix_i;
      pend_q  <= 1'b0;
      phase_q <= PH_ODD;
    end else if (take_odd) begin
      phase_q <= PH_EVEN;
      pend_q  <= !last_i;
      if (!last_i) odd_q <= pix_i;
    end
  end

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(phase_q) && $stable(even_q) && $stable(pend_q) && $stable(odd_q));

  a_r9_line_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_odd && last_i |=> !pend_q && (phase_q == PH_EVEN));
endmodule

// File: rtl/wlp_sum_stage.sv
module wlp_sum_stage #(
  parameter int PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             v_i,
  input  logic [PIX_W-1:0] left_i,
  input  logic [PIX_W-1:0] odd_i,
  input  logic [PIX_W-1:0] right_i,
  output logic             v_o,
  output logic [PIX_W:0]   sum_o,
  output logic [PIX_W-1:0] odd_o,
  output logic [PIX_W-1:0] approx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o      <= 1'b0;
      sum_o    <= '0;
      odd_o    <= '0;
      approx_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        sum_o    <= {1'b0, left_i} + {1'b0, right_i};
        odd_o    <= odd_i;
        approx_o <= left_i;
      end
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o |-> sum_o >= {1'b0, approx_o});
endmodule

// File: rtl/wlp_diff_stage.sv
module wlp_diff_stage #(
  parameter int PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             v_i,
  input  logic [PIX_W:0]   sum_i,
  input  logic [PIX_W-1:0] odd_i,
  input  logic [PIX_W-1:0] approx_i,
  output logic             valid_o,
  output logic [PIX_W:0]   detail_o,
  output logic [PIX_W-1:0] approx_o
);
  localparam int EXT_W = PIX_W + 2;

  logic signed [EXT_W-1:0] sum_s, odd_s, half_s, diff_s;

  assign sum_s  = {1'b0, sum_i};
  assign odd_s  = {2'b00, odd_i};
  assign half_s = sum_s >>> 1;  // floor halving, sign-preserving
  assign diff_s = odd_s - half_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      detail_o <= '0;
      approx_o <= '0;
    end else begin
      valid_o  <= v_i;
      detail_o <= v_i ? diff_s[PIX_W:0] : '0;
      approx_o <= v_i ? approx_i : '0;
    end
  end

  a_r2_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_i |-> diff_s[EXT_W-1] == diff_s[PIX_W]);

  a_r2_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> int'($signed(detail_o)) >= -((1 << PIX_W) - 1));
endmodule

// File: rtl/wlet_predict.sv
module wlet_predict #(
  parameter int PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             valid_i,
  input  logic             last_i,
  output logic             valid_o,
  output logic [PIX_W:0]   detail_o,
  output logic [PIX_W-1:0] approx_o
);
  logic             trip_v, s1_v;
  logic [PIX_W-1:0] t_left, t_odd, t_right, s1_odd, s1_appr;
  logic [PIX_W:0]   s1_sum;

  wlp_pair_ctrl #(.PIX_W(PIX_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_i(pix_i), .valid_i(valid_i),
    .last_i(last_i), .trip_v_o(trip_v), .left_o(t_left), .odd_o(t_odd),
    .right_o(t_right)
  );

  wlp_sum_stage #(.PIX_W(PIX_W)) u_sum (
    .clk_i(clk_i), .rst_ni(rst_ni), .v_i(trip_v), .left_i(t_left),
    .odd_i(t_odd), .right_i(t_right), .v_o(s1_v), .sum_o(s1_sum),
    .odd_o(s1_odd), .approx_o(s1_appr)
  );

  wlp_diff_stage #(.PIX_W(PIX_W)) u_diff (
    .clk_i(clk_i), .rst_ni(rst_ni), .v_i(s1_v), .sum_i(s1_sum),
    .odd_i(s1_odd), .approx_i(s1_appr), .valid_o(valid_o),
    .detail_o(detail_o), .approx_o(approx_o)
  );

  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_v |-> ##2 valid_o);

  a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trip_v |-> ##2 !valid_o);
endmodule

// File: tb/wlet_predict_tb.sv
`timescale 1ns/1ps
module wlet_predict_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pix = '0;
  logic       vin = 1'b0;
  logic       last = 1'b0;
  logic       valid_o;
  logic [8:0] detail_o;
  logic [7:0] approx_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  bit    exp_v [4];
  int    exp_d [4];
  int    exp_a [4];
  string exp_t [4];

  bit       m_phase = 1'b0;
  bit       m_pend = 1'b0;
  int       m_e = 0;
  int       m_o = 0;

  always #2 clk = ~clk;

  wlet_predict u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_i(pix), .valid_i(vin), .last_i(last),
    .valid_o(valid_o), .detail_o(detail_o), .approx_o(approx_o)
  );

  function automatic int pred(int o, int l, int r);
    return o - (l + r) / 2;
  endfunction

  task automatic check_slot();
    int s = cyc % 4;
    n_chk++;
    if (exp_v[s]) begin
      if (!valid_o || int'($signed(detail_o)) != exp_d[s] || int'(approx_o) != exp_a[s]) begin
        n_bad++;
        $display("FAIL %s cyc %0d: valid=%0d detail=%0d approx=%0d, expected valid=1 detail=%0d approx=%0d",
                 exp_t[s], cyc, valid_o, $signed(detail_o), approx_o, exp_d[s], exp_a[s]);
      end
    end else if (valid_o) begin
      n_bad++;
      $display("FAIL %s (R5) cyc %0d: valid=1, expected valid=0", exp_t[s], cyc);
    end
    exp_v[s] = 1'b0;
  endtask

  task automatic push(int o, int l, int r, string tag);
    int s = (cyc + 2) % 4;
    exp_v[s] = 1'b1;
    exp_d[s] = pred(o, l, r);
    exp_a[s] = l;
    exp_t[s] = tag;
  endtask

  task automatic step(int p, bit v, bit lst, string tag);
    @(negedge clk);
    check_slot();
    pix  = 8'(p);
    vin  = v;
    last = lst;
    exp_t[(cyc + 2) % 4] = tag;
    if (v) begin
      if (!m_phase) begin
        if (m_pend) push(m_o, m_e, p, tag);
        m_e = p; m_pend = 1'b0; m_phase = 1'b1;
      end else begin
        if (lst) begin
          push(p, m_e, m_e, (tag == "R1") ? "R7" : tag);
          m_pend = 1'b0;
        end else begin
          m_o = p; m_pend = 1'b1;
        end
        m_phase = 1'b0;
      end
    end
    cyc++;
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(0, 1'b0, 1'b0, "R5");
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin exp_v[i] = 1'b0; exp_t[i] = "R6"; end
    // R10: outputs during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      pix = 8'($urandom); vin = 1'b1; last = 1'b0;
      n_chk++;
      if (valid_o || detail_o != '0 || approx_o != '0) begin
        n_bad++;
        $display("FAIL R10: valid=%0d detail=%0d approx=%0d, expected 0 0 0", valid_o, detail_o, approx_o);
      end
    end
    vin = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;

    // R6: first even and odd give nothing; R1 example, R4 approximation
    step(66, 1, 0, "R6");
    step(48, 1, 0, "R6");
    step(39, 1, 0, "R1");
    step(100, 1, 0, "R4");
    step(7, 1, 0, "R4");
    step(50, 1, 1, "R7");
    flush();
    // R9: new line after last; R2 extremes
    step(255, 1, 0, "R9");
    step(0, 1, 0, "R9");
    step(255, 1, 0, "R2");
    step(255, 1, 0, "R2");
    step(0, 1, 0, "R2");
    step(0, 1, 0, "R3");
    flush();
    // R3: full-scale sum
    step(255, 1, 0, "R3");
    step(200, 1, 0, "R3");
    step(255, 1, 0, "R3");
    step(0, 1, 1, "R7");
    // R7: mirror both signs
    step(10, 1, 0, "R7");
    step(200, 1, 1, "R7");
    step(200, 1, 0, "R7");
    step(10, 1, 1, "R7");
    flush();
    // R8: idle cycles between pairing
    step(66, 1, 0, "R8");
    step(0, 0, 1, "R8");
    step(48, 1, 0, "R8");
    step(255, 0, 1, "R8");
    step(123, 0, 0, "R8");
    step(39, 1, 0, "R8");
    step(1, 1, 1, "R8");
    flush();

    // random lines of even length with idle gaps
    for (int ln = 0; ln < 60; ln++) begin
      int len = 2 * (1 + int'($urandom_range(0, 7)));
      for (int k = 0; k < len; k++) begin
        while ($urandom_range(0, 3) == 0) step(int'($urandom_range(0, 255)), 1'b0, 1'(($urandom_range(0, 1))), "R8");
        step(int'($urandom_range(0, 255)), 1'b1, (k == len - 1), "R1");
      end
    end
    flush();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule